// File: doc/BRIEF.md
# Read Data Reorder Buffer

This block sits between a network storage protocol engine and a memory-mapped user read port. Each read command the user issues reserves one slot of the buffer, and the slot number (the tag) is handed back with the command handshake. Read payload for a command always comes back as one fixed 4096-byte unit, which is 512 beats of 64 bits. The engine writes each beat with the slot tag and the beat's offset inside the unit, and units for different commands may complete in any order.

The block drains whole units to the user port strictly in the order the commands were accepted. It waits on the oldest outstanding slot even when younger slots are already complete. A slot returns to the free pool only once its final beat has been taken by the user. While every slot is reserved, command-ready is low and new commands wait.

The user read port is valid/ready. A beat is transferred on a clock edge where both rd_valid and rd_ready are high. While rd_valid is high and rd_ready is low, the beat on rd_data and rd_last is held unchanged and rd_valid stays high. With rd_ready held high, the port sustains one beat per clock. The engine-side write port has no back-pressure: a beat presented with wr_valid is always stored. The slot count is a build-time parameter (8 to 256 slots, 32 Kbytes to 1 Mbyte at 4096 bytes each). The beats per unit is also a parameter and must be a power of two, at least 2.

Top module: `reorder_read_buffer`

## Requirements
- R1: After synchronous active-high reset, cmd_ready is 1, full is 0, empty is 1 and rd_valid is 0.
- R2: Accepted commands (cmd_valid and cmd_ready high at a clock edge) receive tags 0, 1, 2 … SLOTS-1, then wrap to 0. The tag of the next command is shown on cmd_tag before its handshake.
- R3: When SLOTS commands are outstanding, full is 1 and cmd_ready is 0. cmd_valid is then ignored: no tag is consumed, so the next accepted command still receives the next tag in sequence.
- R4: A beat written with wr_valid goes to buffer location wr_tag × BEATS + wr_beat. A slot becomes eligible for draining when its beat at offset BEATS-1 is written, so that beat must be the last one written for the slot.
- R5: Units are drained in command acceptance order. rd_valid stays 0 while the oldest outstanding slot is incomplete, even if younger slots are complete.
- R6: Each unit is delivered as BEATS beats in ascending offset order. rd_last is 1 only on the beat at offset BEATS-1.
- R7: While rd_valid is 1 and rd_ready is 0, rd_valid stays 1 and rd_data and rd_last stay unchanged on the next clock.
- R8: A slot is freed in the cycle after the handshake of its final beat: full drops and cmd_ready rises then, and not while any beat of the oldest unit is still untaken.
- R9: empty is 1 exactly when no command is outstanding, and rd_valid is 0 whenever empty is 1.
- R10: With complete units waiting and rd_ready held high, the port delivers one beat per clock, so two units drain in no more than 2 × BEATS + 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | User requests a new read command slot |
| cmd_ready | output | 1 | A free slot exists and a command can be accepted |
| cmd_tag | output | $clog2(SLOTS) | Tag given to the command accepted at this handshake |
| wr_valid | input | 1 | Engine presents one payload beat |
| wr_tag | input | $clog2(SLOTS) | Slot the beat belongs to |
| wr_beat | input | $clog2(BEATS) | Offset of the beat inside its unit |
| wr_data | input | 64 | Payload beat |
| rd_valid | output | 1 | A beat is offered on the user read port |
| rd_ready | input | 1 | User accepts the offered beat |
| rd_data | output | 64 | Beat delivered to the user |
| rd_last | output | 1 | Offered beat is the final beat of its unit |
| full | output | 1 | Every slot is reserved |
| empty | output | 1 | No slot is reserved |

## Verification
A drain pointer that skips or repeats a slot shows up on the first beat after the bad advance: rd_data carries another command's pattern, or rd_valid rises before the oldest unit is complete. A beat counter or last-flag error shows within one unit: rd_last lands on the wrong beat, or the offset pattern in rd_data breaks. Faults in the free count or the allocation pointer show at the command side. The count or pointer errors appear as cmd_ready or full changing one beat too early or too late around a unit's final beat, or as a wrong cmd_tag on the next command after a full buffer drains.

// File: rtl/rrb_pkg.sv
package rrb_pkg;
  localparam int WORD_W = 64;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/rrb_alloc.sv
module rrb_alloc #(
  parameter int SLOTS = 8,
  parameter int TAG_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic             free_slot,
  output logic             cmd_ready,
  output logic [TAG_W-1:0] cmd_tag,
  output logic             full,
  output logic             empty
);
  logic [CNT_W-1:0] used_q;
  logic [TAG_W-1:0] aptr_q;
  logic             accept;

  assign full      = (used_q == CNT_W'(SLOTS));
  assign empty     = (used_q == '0);
  assign cmd_ready = !full;
  assign cmd_tag   = aptr_q;
  assign accept    = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      used_q <= '0;
      aptr_q <= '0;
    end else begin
      if (accept)
        aptr_q <= (aptr_q == TAG_W'(SLOTS - 1)) ? '0 : aptr_q + 1'b1;
      case ({accept, free_slot})
        2'b10:   used_q <= used_q + 1'b1;
        2'b01:   used_q <= used_q - 1'b1;
        default: used_q <= used_q;
      endcase
    end
  end

  // R9: a slot can only be returned while one is outstanding
  p_no_free_empty_r9: assert property (@(posedge clk) disable iff (rst)
    free_slot |-> !empty);

  // R3: with no slot returned, a full buffer keeps its allocation pointer
  p_full_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (full && !free_slot) |=> (full && $stable(cmd_tag)));
endmodule

// File: rtl/rrb_slot_state.sv
module rrb_slot_state #(
  parameter int SLOTS = 8,
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [TAG_W-1:0] clr_idx,
  output logic [SLOTS-1:0] filled
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hit_set, hit_clr;
    assign hit_set = set_en && (set_idx == TAG_W'(s));
    assign hit_clr = clr_en && (clr_idx == TAG_W'(s));
    always_ff @(posedge clk) begin
      if (rst)          filled[s] <= 1'b0;
      else if (hit_set) filled[s] <= 1'b1;
      else if (hit_clr) filled[s] <= 1'b0;
    end
  end

  // R4: a unit completes once per reservation
  p_fill_once_r4: assert property (@(posedge clk) disable iff (rst)
    set_en |-> !filled[set_idx]);
endmodule

// File: rtl/rrb_store.sv
module rrb_store #(
  parameter int DEPTH  = 4096,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  rrb_pkg::word_t    wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output rrb_pkg::word_t    rdata
);
  rrb_pkg::word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rrb_drain.sv
module rrb_drain #(
  parameter int SLOTS  = 8,
  parameter int BEATS  = 512,
  parameter int TAG_W  = 3,
  parameter int OFF_W  = 9,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOTS-1:0]  filled,
  output logic              clr_en,
  output logic [TAG_W-1:0]  clr_idx,
  output logic              re,
  output logic [ADDR_W-1:0] raddr,
  input  rrb_pkg::word_t    rdata,
  output logic              rd_valid,
  input  logic              rd_ready,
  output rrb_pkg::word_t    rd_data,
  output logic              rd_last,
  output logic              free_slot
);
  logic [TAG_W-1:0] rp_q;
  logic [OFF_W-1:0] bc_q;
  logic             infl_q, infl_last_q;
  rrb_pkg::word_t   fd_q [2];
  logic [1:0]       fl_q;
  logic             fw_q, fr_q;
  logic [1:0]       occ_q;
  logic [2:0]       total;
  logic             pop, push, issue, at_last;

  assign pop      = rd_valid && rd_ready;
  assign push     = infl_q;
  assign total    = {1'b0, occ_q} + {2'b0, infl_q};
  assign at_last  = (bc_q == OFF_W'(BEATS - 1));
  assign issue    = filled[rp_q] && ((total < 3'd2) || ((total == 3'd2) && pop));

  assign re        = issue;
  assign raddr     = {rp_q, bc_q};
  assign clr_en    = issue && at_last;
  assign clr_idx   = rp_q;
  assign rd_valid  = (occ_q != 2'd0);
  assign rd_data   = fd_q[fr_q];
  assign rd_last   = fl_q[fr_q];
  assign free_slot = pop && rd_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      rp_q        <= '0;
      bc_q        <= '0;
      infl_q      <= 1'b0;
      infl_last_q <= 1'b0;
      fw_q        <= 1'b0;
      fr_q        <= 1'b0;
      occ_q       <= 2'd0;
      fl_q        <= 2'b00;
    end else begin
      infl_q      <= issue;
      infl_last_q <= issue && at_last;
      if (issue) begin
        if (at_last) begin
          bc_q <= '0;
          rp_q <= (rp_q == TAG_W'(SLOTS - 1)) ? '0 : rp_q + 1'b1;
        end else begin
          bc_q <= bc_q + 1'b1;
        end
      end
      if (push) begin
        fd_q[fw_q] <= rdata;
        fl_q[fw_q] <= infl_last_q;
        fw_q       <= ~fw_q;
      end
      if (pop) fr_q <= ~fr_q;
      occ_q <= occ_q + {1'b0, push} - {1'b0, pop};
    end
  end

  // R7: an offered beat is held until taken
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_last)));

  // R6: the last flag marks every BEATS-th delivered beat, tracked by a separate counter
  logic [OFF_W-1:0] seen_q;
  always_ff @(posedge clk) begin
    if (rst)      seen_q <= '0;
    else if (pop) seen_q <= (seen_q == OFF_W'(BEATS - 1)) ? '0 : seen_q + 1'b1;
  end
  p_last_pos_r6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_last == (seen_q == OFF_W'(BEATS - 1))));
endmodule

// File: rtl/reorder_read_buffer.sv
module reorder_read_buffer #(
  parameter int SLOTS = 8,
  parameter int BEATS = 512,
  localparam int TAG_W  = $clog2(SLOTS),
  localparam int OFF_W  = $clog2(BEATS),
  localparam int ADDR_W = TAG_W + OFF_W,
  localparam int CNT_W  = $clog2(SLOTS + 1),
  localparam int DEPTH  = SLOTS * BEATS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  output logic [TAG_W-1:0]       cmd_tag,
  input  logic                   wr_valid,
  input  logic [TAG_W-1:0]       wr_tag,
  input  logic [OFF_W-1:0]       wr_beat,
  input  logic [rrb_pkg::WORD_W-1:0] wr_data,
  output logic                   rd_valid,
  input  logic                   rd_ready,
  output logic [rrb_pkg::WORD_W-1:0] rd_data,
  output logic                   rd_last,
  output logic                   full,
  output logic                   empty
);
  logic [SLOTS-1:0]  filled;
  logic              free_slot, clr_en, re, set_en;
  logic [TAG_W-1:0]  clr_idx;
  logic [ADDR_W-1:0] raddr;
  rrb_pkg::word_t    rdata;

  assign set_en = wr_valid && (wr_beat == OFF_W'(BEATS - 1));

  rrb_alloc #(.SLOTS(SLOTS), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_alloc (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .free_slot(free_slot),
    .cmd_ready(cmd_ready), .cmd_tag(cmd_tag), .full(full), .empty(empty));

  rrb_slot_state #(.SLOTS(SLOTS), .TAG_W(TAG_W)) u_state (
    .clk(clk), .rst(rst), .set_en(set_en), .set_idx(wr_tag),
    .clr_en(clr_en), .clr_idx(clr_idx), .filled(filled));

  rrb_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .we(wr_valid), .waddr({wr_tag, wr_beat}), .wdata(wr_data),
    .re(re), .raddr(raddr), .rdata(rdata));

  rrb_drain #(.SLOTS(SLOTS), .BEATS(BEATS), .TAG_W(TAG_W), .OFF_W(OFF_W),
              .ADDR_W(ADDR_W)) u_drain (
    .clk(clk), .rst(rst), .filled(filled), .clr_en(clr_en), .clr_idx(clr_idx),
    .re(re), .raddr(raddr), .rdata(rdata), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last),
    .free_slot(free_slot));

  // R9: nothing is offered when no command is outstanding
  p_empty_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    empty |-> !rd_valid);

  // R8: a full buffer stays full until a final beat is taken
  p_free_on_last_r8: assert property (@(posedge clk) disable iff (rst)
    (full && !(rd_valid && rd_ready && rd_last)) |=> full);
endmodule

// File: tb/reorder_read_buffer_test.sv
module reorder_read_buffer_test;
  localparam int SLOTS = 4;
  localparam int BEATS = 8;
  localparam int TAG_W = $clog2(SLOTS);
  localparam int OFF_W = $clog2(BEATS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, wr_valid = 1'b0, rd_ready = 1'b0;
  logic [TAG_W-1:0] wr_tag = '0;
  logic [OFF_W-1:0] wr_beat = '0;
  logic [63:0] wr_data = '0;
  logic cmd_ready, rd_valid, rd_last, full, empty;
  logic [TAG_W-1:0] cmd_tag;
  logic [63:0] rd_data;

  reorder_read_buffer #(.SLOTS(SLOTS), .BEATS(BEATS)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_tag(cmd_tag), .wr_valid(wr_valid), .wr_tag(wr_tag), .wr_beat(wr_beat),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_last(rd_last), .full(full), .empty(empty));

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  int issued = 0, rd_seq = 0, rd_beat = 0, pops = 0;
  int pop_limit = 1 << 30;
  int mode = 0;
  int cyc = 0;
  int slot_seq [SLOTS];
  logic held = 1'b0, held_last;
  logic [63:0] held_data;

  function automatic logic [63:0] dfun(int s, int b);
    return {32'(s) ^ 32'h5A00_0000, (32'(b) << 8) ^ (32'(s) * 32'h9E37)};
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // user read side: decides ready at each falling edge, checks every transfer
  always @(negedge clk) begin
    bit r;
    if (rst) begin
      rd_ready = 1'b0;
    end else begin
      if (rd_valid && held) begin
        check(rd_data == held_data, "R7", "held data", rd_data, held_data);
        check(rd_last == held_last, "R7", "held last", rd_last, held_last);
      end
      r = (pops < pop_limit) && (mode == 1 || (mode == 0 && ($urandom % 4) != 0));
      rd_ready = r;
      if (rd_valid && r) begin
        check(rd_data == dfun(rd_seq, rd_beat), "R5", "beat data", rd_data, dfun(rd_seq, rd_beat));
        check(rd_last == (rd_beat == BEATS - 1), "R6", "last flag", rd_last, rd_beat == BEATS - 1);
        pops++;
        held = 1'b0;
        if (rd_beat == BEATS - 1) begin rd_beat = 0; rd_seq++; end
        else rd_beat++;
      end else begin
        held = rd_valid;
        held_data = rd_data;
        held_last = rd_last;
      end
    end
  end

  task automatic issue_cmd();
    @(negedge clk);
    check(cmd_ready == 1'b1, "R2", "ready before command", cmd_ready, 1);
    check(cmd_tag == TAG_W'(issued % SLOTS), "R2", "command tag", cmd_tag, issued % SLOTS);
    slot_seq[cmd_tag] = issued;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    issued++;
  endtask

  task automatic write_slot(int tag);
    int start = $urandom % (BEATS - 1);
    for (int i = 0; i < BEATS; i++) begin
      int b = (i == BEATS - 1) ? BEATS - 1 : (start + i) % (BEATS - 1);
      @(negedge clk);
      if (($urandom % 4) == 0) begin
        wr_valid = 1'b0;
        @(negedge clk);
      end
      wr_valid = 1'b1;
      wr_tag   = TAG_W'(tag);
      wr_beat  = OFF_W'(b);
      wr_data  = dfun(slot_seq[tag], b);
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "WD", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R1", "reset cmd_ready", cmd_ready, 1);
    check(full == 1'b0, "R1", "reset full", full, 0);
    check(empty == 1'b1, "R1", "reset empty", empty, 1);
    check(rd_valid == 1'b0, "R1", "reset rd_valid", rd_valid, 0);

    // directed: fill, ignore extra commands, out-of-order completion, release timing
    pop_limit = 0;
    for (int i = 0; i < SLOTS; i++) issue_cmd();
    @(negedge clk);
    check(full == 1'b1, "R3", "full when all reserved", full, 1);
    check(cmd_ready == 1'b0, "R3", "ready low when full", cmd_ready, 0);
    check(empty == 1'b0, "R9", "not empty when outstanding", empty, 0);
    cmd_valid = 1'b1;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    for (int t = SLOTS - 1; t >= 1; t--) write_slot(t);
    pop_limit = 1 << 30;
    repeat (6) @(negedge clk);
    check(rd_valid == 1'b0, "R5", "stall on incomplete oldest slot", rd_valid, 0);
    pop_limit = BEATS - 1;
    write_slot(0);
    wait (pops == BEATS - 1);
    repeat (5) @(negedge clk);
    check(cmd_ready == 1'b0, "R8", "slot kept until final beat", cmd_ready, 0);
    check(full == 1'b1, "R8", "full kept until final beat", full, 1);
    pop_limit = BEATS;
    wait (pops == BEATS);
    @(negedge clk);
    check(cmd_ready == 1'b1, "R8", "slot freed after final beat", cmd_ready, 1);
    check(full == 1'b0, "R8", "full cleared after final beat", full, 0);
    pop_limit = 1 << 30;
    issue_cmd();  // R3: tag must be 0, proving the commands while full were ignored
    write_slot((issued - 1) % SLOTS);
    wait (rd_seq == issued);
    repeat (2) @(negedge clk);
    check(empty == 1'b1, "R9", "empty after drain", empty, 1);
    check(rd_valid == 1'b0, "R9", "quiet after drain", rd_valid, 0);

    // R10: sustained drain with ready held high
    begin
      int t0, target;
      pop_limit = pops;
      issue_cmd();
      issue_cmd();
      write_slot((issued - 2) % SLOTS);
      write_slot((issued - 1) % SLOTS);
      repeat (4) @(negedge clk);
      target = pops + 2 * BEATS;
      mode = 1;
      pop_limit = 1 << 30;
      t0 = cyc;
      wait (pops == target);
      check(cyc - t0 <= 2 * BEATS + 2, "R10", "cycles for two units", cyc - t0, 2 * BEATS + 2);
      mode = 0;
      wait (rd_seq == issued);
    end

    // random rounds: random batch sizes, random completion order, random back-pressure
    for (int round = 0; round < 40; round++) begin
      int n = 1 + $urandom % SLOTS;
      int pend [$];
      for (int i = 0; i < n; i++) begin
        pend.push_back(issued % SLOTS);
        issue_cmd();
      end
      while (pend.size() > 0) begin
        int k = $urandom % pend.size();
        write_slot(pend[k]);
        pend.delete(k);
      end
      wait (rd_seq == issued);
      repeat (2) @(negedge clk);
      check(empty == 1'b1, "R9", "empty after random round", empty, 1);
    end
    check(pops == issued * BEATS, "R6", "total beats delivered", pops, issued * BEATS);
    finish_run();
  end
endmodule